// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

An 8-bit full-duplex serial port that moves one byte out and one byte in per frame on a shared transfer clock. The clock is generated inside the block from a prescaled system clock and an 8-bit divider, or it is taken from an external clock pin. The transmit path holds one byte in a buffer while another shifts out. The receive path moves each completed byte into a receive buffer and flags it.

The transmitter is the master of every frame. Reception only happens while a transmit frame is shifting. To receive, software enables both directions and writes a byte, possibly a dummy, to the transmit buffer. This also holds when the clock comes from outside. The internal clock toggles only while a frame is in flight. If a byte is waiting when a frame ends, the next frame follows with no gap.

Two interrupt request outputs stay high until they are acknowledged. The transmit request fires either when the buffer empties or when the shift register becomes idle, depending on a select input. The receive request fires for every completed byte.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, tx_buf_empty=1, tx_idle=1, rx_full=0, rx_overrun=0, both interrupt requests are 0, sdo=1, and sck_out rests at its idle level.
- R2: With the internal clock, one transfer clock period lasts 2*(cfg_div+1)*P system clocks. P is 1, 8 or 32 for cfg_src = 0, 1 or 2/3.
- R3: With cfg_pol=0, the idle clock is high, sdo changes on the falling edge and sdi is sampled on the rising edge. With cfg_pol=1, both edges swap and the idle clock is low.
- R4: A frame carries 8 bits, least significant bit first. With sdo looped back to sdi, the received byte equals the sent byte.
- R5: A buffered byte moves into the shift register as soon as the shift register is free and transmit is enabled. At that moment tx_buf_empty rises, and with cfg_irq_sel=0 tx_irq is raised.
- R6: tx_idle is 0 while a frame is shifting. It returns to 1 after the last bit when no byte is waiting. With cfg_irq_sel=1, tx_irq is raised at that moment and not when the byte is loaded.
- R7: The internal clock stops when no byte is waiting at frame end. Clearing cfg_tx_en aborts a frame: tx_idle returns to 1 and the clock parks at its idle level.
- R8: After the 8th sampled bit with cfg_rx_en=1, the byte appears on rx_data, rx_full rises and rx_irq is raised. With cfg_rx_en=0, rx_full stays 0.
- R9: rx_rd clears rx_full and rx_overrun. A byte that completes while rx_full=1 and no read is pending sets rx_overrun and overwrites rx_data.
- R10: tx_irq and rx_irq stay at 1 until their acknowledge input is pulsed.
- R11: A byte written during a frame is sent directly after it, and every clock period across the two frames has the same length.
- R12: With cfg_ext=1, sck_oe=0, and the shift and sample steps follow the edges of sck_in under the same polarity rule as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_ext | input | 1 | 1 selects external clock from sck_in |
| cfg_pol | input | 1 | Clock polarity select |
| cfg_irq_sel | input | 1 | tx_irq source: 0 buffer empty, 1 shift register idle |
| cfg_src | input | 2 | Divider count source: 0 /1, 1 /8, else /32 |
| cfg_div | input | 8 | Divider value n |
| tx_wr | input | 1 | Write tx_data into the transmit buffer |
| tx_data | input | 8 | Transmit byte |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 8 | Receive buffer |
| tx_irq_ack | input | 1 | Clears tx_irq |
| rx_irq_ack | input | 1 | Clears rx_irq |
| sck_in | input | 1 | External transfer clock |
| sck_out | output | 1 | Generated transfer clock |
| sck_oe | output | 1 | Drive enable for sck_out |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| tx_buf_empty | output | 1 | Transmit buffer empty |
| tx_idle | output | 1 | Transmit shift register idle |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_overrun | output | 1 | A byte overwrote an unread byte |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench keeps the default data width, divider width and prescaler ratios. It drives cfg_div only over 0 to 3. This keeps a frame between 16 and 2048 system clocks, so all three count sources, random bytes, both polarities and the external clock mode fit in one short run. Divider value 0 with the /1 source gives a clock that toggles every system cycle. This exposes any off-by-one in the half-period count and any gap between back-to-back frames.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DW = 8,
  parameter int DIVW = 8,
  parameter int PRE_MID = 8,
  parameter int PRE_SLOW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_tx_en,
  input  logic            cfg_rx_en,
  input  logic            cfg_ext,
  input  logic            cfg_pol,
  input  logic            cfg_irq_sel,
  input  logic [1:0]      cfg_src,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            tx_wr,
  input  logic [DW-1:0]   tx_data,
  input  logic            rx_rd,
  output logic [DW-1:0]   rx_data,
  input  logic            tx_irq_ack,
  input  logic            rx_irq_ack,
  input  logic            sck_in,
  output logic            sck_out,
  output logic            sck_oe,
  output logic            sdo,
  input  logic            sdi,
  output logic            tx_buf_empty,
  output logic            tx_idle,
  output logic            rx_full,
  output logic            rx_overrun,
  output logic            tx_irq,
  output logic            rx_irq
);
  localparam int PW = $clog2(PRE_SLOW);
  localparam int BW = $clog2(DW);

  logic [PW-1:0]   pre, pre_lim;
  logic [DIVW-1:0] hcnt;
  logic [2:0]      ck_s;
  logic [BW-1:0]   bitcnt;
  logic [DW-1:0]   tbuf, tsr, rsr;
  logic            buf_full, active, phase;
  logic            tick, expire, ext_edge, launch, sample;
  logic            start, frame_end, reload, load;

  always_comb begin
    case (cfg_src)
      2'd0:    pre_lim = '0;
      2'd1:    pre_lim = PW'(PRE_MID - 1);
      default: pre_lim = PW'(PRE_SLOW - 1);
    endcase
  end

  assign tick      = (pre == pre_lim);
  assign expire    = active && !cfg_ext && tick && (hcnt == cfg_div);
  assign ext_edge  = active && cfg_ext && (ck_s[1] ^ ck_s[2]);
  assign launch    = (expire && !phase) || (ext_edge && (ck_s[1] == cfg_pol));
  assign sample    = (expire && phase)  || (ext_edge && (ck_s[1] != cfg_pol));
  assign start     = !active && cfg_tx_en && buf_full;
  assign frame_end = sample && (bitcnt == BW'(DW - 1));
  assign reload    = frame_end && cfg_tx_en && buf_full;
  assign load      = start || reload;

  assign sck_out      = cfg_pol ? phase : ~phase;
  assign sck_oe       = ~cfg_ext;
  assign tx_buf_empty = ~buf_full;
  assign tx_idle      = ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_s <= '1;
    else        ck_s <= {ck_s[1:0], sck_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      hcnt <= '0;
    end else if (!active) begin
      pre  <= '0;
      hcnt <= '0;
    end else if (tick) begin
      pre  <= '0;
      hcnt <= (hcnt == cfg_div) ? '0 : hcnt + 1'b1;
    end else begin
      pre  <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= 1'b0;
    end else begin
      if (!cfg_tx_en)                  active <= 1'b0;
      else if (start)                  active <= 1'b1;
      else if (frame_end && !buf_full) active <= 1'b0;
      if (!cfg_tx_en || !active)       phase <= 1'b0;
      else if (expire)                 phase <= ~phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf     <= '0;
      buf_full <= 1'b0;
      tsr      <= '0;
      sdo      <= 1'b1;
      bitcnt   <= '0;
    end else begin
      if (tx_wr) tbuf <= tx_data;
      buf_full <= tx_wr || (buf_full && !load);
      if (load) begin
        tsr    <= tbuf;
        bitcnt <= '0;
      end else begin
        if (launch) begin
          sdo <= tsr[0];
          tsr <= tsr >> 1;
        end
        if (sample) bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsr        <= '0;
      rx_data    <= '0;
      rx_full    <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (sample) rsr <= {sdi, rsr[DW-1:1]};
      if (frame_end && cfg_rx_en) begin
        rx_data    <= {sdi, rsr[DW-1:1]};
        rx_full    <= 1'b1;
        rx_overrun <= rx_full && !rx_rd;
      end else if (rx_rd) begin
        rx_full    <= 1'b0;
        rx_overrun <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      if ((load && !cfg_irq_sel) || (frame_end && !reload && cfg_irq_sel)) tx_irq <= 1'b1;
      else if (tx_irq_ack) tx_irq <= 1'b0;
      if (frame_end && cfg_rx_en) rx_irq <= 1'b1;
      else if (rx_irq_ack)        rx_irq <= 1'b0;
    end
  end

  a_r5_write_fills_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_buf_empty);
  a_r8_full_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> rx_irq);
  a_r7_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx_en |=> tx_idle);
  a_r9_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_full));
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && !cfg_ext) |-> (sck_out != cfg_pol));
  a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !tx_irq_ack) |=> tx_irq);
endmodule

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  logic clk = 0, rst_n = 0;
  logic cfg_tx_en = 0, cfg_rx_en = 0, cfg_ext = 0, cfg_pol = 0, cfg_irq_sel = 0;
  logic [1:0] cfg_src = 0;
  logic [7:0] cfg_div = 0, tx_data = 0, rx_data;
  logic tx_wr = 0, rx_rd = 0, tx_irq_ack = 0, rx_irq_ack = 0;
  logic sck_in = 1, ext_sdi = 0, sdi;
  logic sck_out, sck_oe, sdo, tx_buf_empty, tx_idle, rx_full, rx_overrun, tx_irq, rx_irq;
  int checks = 0, errors = 0;
  int cnt = 0, mn = 0, mx = 0, falls = 0;
  logic prev_sck = 1;

  always #2 clk = ~clk;
  assign sdi = cfg_ext ? ext_sdi : sdo;

  sync_serial_port uut (.clk, .rst_n, .cfg_tx_en, .cfg_rx_en, .cfg_ext, .cfg_pol,
    .cfg_irq_sel, .cfg_src, .cfg_div, .tx_wr, .tx_data, .rx_rd, .rx_data,
    .tx_irq_ack, .rx_irq_ack, .sck_in, .sck_out, .sck_oe, .sdo, .sdi,
    .tx_buf_empty, .tx_idle, .rx_full, .rx_overrun, .tx_irq, .rx_irq);

  always @(negedge clk) begin
    cnt = cnt + 1;
    if (prev_sck != sck_out && sck_out == cfg_pol) begin
      if (falls > 0) begin
        if (cnt < mn) mn = cnt;
        if (cnt > mx) mx = cnt;
      end
      falls = falls + 1;
      cnt = 0;
    end
    prev_sck = sck_out;
  end

  function automatic int exp_period(input logic [7:0] n, input logic [1:0] s);
    return 2 * (n + 1) * ((s == 0) ? 1 : (s == 1) ? 8 : 32);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic meas_reset();
    mn = 1 << 30; mx = 0; falls = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic rd();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic ack();
    @(negedge clk); tx_irq_ack = 1; rx_irq_ack = 1;
    @(negedge clk); tx_irq_ack = 0; rx_irq_ack = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(tx_idle && tx_buf_empty)) @(negedge clk);
    cyc(2);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    chk(tx_buf_empty && tx_idle && !rx_full && !rx_overrun && !tx_irq && !rx_irq && sdo && sck_out,
        "R1 reset state", {tx_buf_empty, tx_idle, rx_full, rx_overrun, tx_irq, rx_irq, sdo, sck_out}, 8'b11000011);
    rst_n = 1;
    cfg_tx_en = 1; cfg_rx_en = 1;

    // R2 R4 R3: random bytes over dividers and sources, loopback
    for (int i = 0; i < 12; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      cfg_div = 8'($urandom_range(0, 3));
      cfg_src = 2'($urandom_range(0, 2));
      cfg_pol = (i % 3 == 2);
      cyc(2);
      meas_reset();
      wr(d);
      wait_idle();
      chk(rx_full && rx_data == d, "R4 loopback byte", rx_data, d);
      chk(mn == exp_period(cfg_div, cfg_src) && mx == mn, "R2 clock period", mx, exp_period(cfg_div, cfg_src));
      chk(sck_out == !cfg_pol, "R3 idle level", sck_out, !cfg_pol);
      rd(); ack();
    end
    cfg_pol = 0;

    // R5 R6 R10: load and interrupt timing, source select 0
    cfg_div = 3; cfg_src = 1; cfg_irq_sel = 0;
    wr(8'hA5);
    cyc(1);
    chk(tx_buf_empty && !tx_idle && tx_irq, "R5 load sets empty and irq", {tx_buf_empty, tx_idle, tx_irq}, 3'b101);
    cyc(100);
    chk(tx_irq, "R10 tx_irq held", tx_irq, 1);
    wait_idle();
    chk(tx_idle && rx_irq, "R6 idle after frame", {tx_idle, rx_irq}, 2'b11);
    ack();
    chk(!tx_irq && !rx_irq, "R10 ack clears", {tx_irq, rx_irq}, 0);
    rd();

    // R6: source select 1 fires at the end only
    cfg_irq_sel = 1;
    wr(8'h3C);
    cyc(10);
    chk(!tx_irq && !tx_idle, "R6 no irq at load", {tx_irq, tx_idle}, 0);
    wait_idle();
    chk(tx_irq, "R6 irq at idle", tx_irq, 1);
    ack(); rd();
    cfg_irq_sel = 0;

    // R11 R9: back to back, overrun
    cfg_div = 0; cfg_src = 0;
    meas_reset();
    wr(8'h11);
    wr(8'h22);
    wait_idle();
    chk(falls == 16 && mn == 2 && mx == 2, "R11 no gap", mx, 2);
    chk(rx_overrun && rx_data == 8'h22, "R9 overrun overwrite", {rx_overrun, rx_data}, {1'b1, 8'h22});
    rd();
    chk(!rx_full && !rx_overrun, "R9 read clears", {rx_full, rx_overrun}, 0);
    ack();

    // R8: receive disabled
    cfg_rx_en = 0;
    wr(8'h5A);
    wait_idle();
    chk(!rx_full && !rx_irq, "R8 rx disabled", {rx_full, rx_irq}, 0);
    cfg_rx_en = 1; ack();

    // R7: abort mid-frame
    cfg_div = 3; cfg_src = 1;
    wr(8'hF0);
    cyc(100);
    cfg_tx_en = 0;
    cyc(3);
    chk(tx_idle && sck_out, "R7 abort", {tx_idle, sck_out}, 2'b11);
    meas_reset();
    cyc(200);
    chk(falls == 0 && sck_out, "R7 clock stopped", falls, 0);
    cfg_tx_en = 1; ack();

    // R12: external clock
    cfg_ext = 1;
    cyc(4);
    chk(!sck_oe, "R12 sck_oe off", sck_oe, 0);
    begin
      logic [7:0] tb_out, got;
      tb_out = 8'h96; got = 0;
      wr(8'hC3);
      for (int b = 0; b < 8; b++) begin
        cyc(8); sck_in = 0; ext_sdi = tb_out[b];
        cyc(8); got[b] = sdo; sck_in = 1;
      end
      cyc(8);
      chk(got == 8'hC3, "R12 external tx", got, 8'hC3);
      chk(rx_full && rx_data == tb_out, "R12 external rx", rx_data, tb_out);
      chk(tx_idle, "R12 idle after frame", tx_idle, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule